// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits on the host side of a parallel NOR flash model and interprets the bus write cycles aimed at it. It qualifies the write strobe with chip enable and output enable. From each write cycle it takes the address at the moment the cycle opens and the data at the moment it closes. The accepted writes drive a state machine that recognises the multi-cycle unlock sequences and chooses the operating mode: array read, autoselect, program set-up, erase set-up or unlock bypass. When a sequence completes, the block sends the embedded-algorithm engine a one-cycle start request, together with the operation code and the latched address and data.

While the engine reports busy, every write is dropped and the decoder state does not move. In autoselect mode, reads return the manufacturer, device and continuation codes, or the protection flag of the addressed sector. Any cycle that does not fit the sequence sends the decoder back to array read.

States: `ST_READ` (array read), `ST_UL1` (first unlock seen), `ST_UL2` (second unlock seen), `ST_PGM` (program set-up, waiting for address and data), `ST_ERS` (erase set-up), `ST_EUL1` and `ST_EUL2` (the two erase unlocks), `ST_AUTO` (autoselect), `ST_BYP` (unlock bypass), `ST_BPGM` (bypass program set-up), `ST_BRST` (bypass reset, first half). Transitions:
- read→UL1 on AAh at 555h.
- UL1→UL2 on 55h at 2AAh.
- UL2→PGM on A0h at 555h.
- UL2→ERS on 80h at 555h.
- UL2→AUTO on 90h at 555h.
- UL2→BYP on 20h at 555h.
- PGM→read on any write, issuing a program start.
- ERS→EUL1 on AAh at 555h.
- EUL1→EUL2 on 55h at 2AAh.
- EUL2→read on 10h at 555h (chip erase start) or on 30h at any address (sector erase start).
- AUTO→read on F0h.
- BYP→BPGM on A0h.
- BPGM→BYP on any write, issuing a program start.
- BYP→BRST on 90h.
- BRST→read on 00h, and BRST→BYP on any other value.
- Every other write in UL1, UL2, ERS, EUL1 or EUL2 returns the decoder to read.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the decoder is in array read: `start` is 0 and `id_valid` stays 0 during a read.
- R2: The four-write program sequence (AAh at 555h, 55h at 2AAh, A0h at 555h, then address and data) gives one `start` pulse with `start_op`=01 and the fourth write's address and data. The earlier writes give no pulse.
- R3: The six-write erase sequence (AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh) gives a `start` pulse when it is followed by its last write. The last write is 10h at 555h for chip erase (`start_op`=10) or 30h at the sector address (`start_op`=11, `start_addr` = that address).
- R4: In unlock bypass (entered by 20h at 555h after the two unlocks), A0h followed by an address/data write gives a program start each time. The address of the A0h write is not checked.
- R5: In unlock bypass, writes other than A0h and 90h are ignored and the decoder stays in bypass. 90h followed by 00h returns it to array read.
- R6: A write with a wrong address or data value, or one out of sequence, returns the decoder to array read. No start results, and a new sequence must begin from the first unlock.
- R7: F0h at any address, written between the cycles of an unlock or erase sequence, returns the decoder to array read.
- R8: In autoselect, a read with both enables low sets `id_valid`. Offset 00h returns 37h, 01h returns `DEV_ID`, 03h returns 7Fh, and 02h returns 01h if the sector is protected and 00h if not. The offset is the low 8 address bits; the sector is the top `SECT_W` address bits, indexing `prot_map`. Reads may be repeated.
- R9: Autoselect is left only by F0h. Other writes keep the decoder there.
- R10: While `busy` is 1, writes are ignored and the decoder state is kept, so a sequence interrupted by busy resumes where it stood.
- R11: A write cycle opens when ce_n and we_n are both low with oe_n high. The address is taken in the first clock of the open cycle and the data in its last clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| busy | input | 1 | Embedded algorithm running |
| prot_map | input | NSECT | Per-sector protection flags |
| start | output | 1 | One-cycle start request |
| start_op | output | 2 | 01 program, 10 chip erase, 11 sector erase |
| start_addr | output | ADDR_W | Latched operation address |
| start_data | output | DATA_W | Latched operation data |
| id_valid | output | 1 | Autoselect read data valid |
| id_data | output | DATA_W | Autoselect read data |

## Verification
The complete program, chip-erase and sector-erase sequences are compared with sequences that are broken by a wrong address, a wrong value, an early reset or writes in the wrong order. This shows that only exact sequences produce starts. Bypass programming is run twice in a row with a stray write between the two runs, and is then followed by the bypass exit. This separates the shortcut path from ordinary read mode. Every write varies the address and data inside the open cycle and lets chip enable fall early, so a capture taken at the wrong edge shows up in the start fields. The busy test stops a sequence partway, injects writes, and finishes it afterwards, which shows that the state is held rather than cleared.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UL1,
        ST_UL2,
        ST_PGM,
        ST_ERS,
        ST_EUL1,
        ST_EUL2,
        ST_AUTO,
        ST_BYP,
        ST_BPGM,
        ST_BRST
    } dec_state_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PGM   = 2'b01,
        OP_CHIP  = 2'b10,
        OP_SECT  = 2'b11
    } op_code_t;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECTOR   = 8'h30;
    localparam logic [7:0] CMD_AUTOSEL  = 8'h90;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_BYP_EXIT = 8'h00;

    localparam logic [10:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLOCK_ADDR_B = 11'h2AA;

    localparam logic [7:0] MANUF_CODE = 8'h37;
    localparam logic [7:0] CONT_CODE  = 8'h7F;

endpackage

// File: rtl/nor_wr_capture.sv
module nor_wr_capture #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_data
);

    logic wr_open;
    logic wr_open_q;

    // A write is open only while both strobes are low and outputs are off.
    assign wr_open = ~ce_n & ~we_n & oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_open_q <= 1'b0;
            acc_addr  <= '0;
            acc_data  <= '0;
        end else begin
            wr_open_q <= wr_open;
            // Address: the later of the two falling edges opens the cycle.
            if (wr_open && !wr_open_q) begin
                acc_addr <= addr;
            end
            // Data: keep following the bus until the first strobe rises.
            if (wr_open) begin
                acc_data <= wdata;
            end
        end
    end

    assign wr_stb = wr_open_q & ~wr_open;

endmodule

// File: rtl/nor_id_mux.sv
module nor_id_mux #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int SECT_W = 4,
    parameter int OFS_W  = 8,
    parameter logic [DATA_W-1:0] DEV_ID = 8'h1A,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              in_auto,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSECT-1:0]  prot_map,
    output logic              id_valid,
    output logic [DATA_W-1:0] id_data
);
    import nor_cmd_pkg::*;

    logic [SECT_W-1:0] sect_idx;
    logic [OFS_W-1:0]  ofs;

    assign sect_idx = addr[ADDR_W-1 -: SECT_W];
    assign ofs      = addr[OFS_W-1:0];

    always_comb begin
        id_valid = in_auto & ~ce_n & ~oe_n;
        id_data  = '0;
        if (id_valid) begin
            unique case (ofs)
                OFS_W'(0): id_data = DATA_W'(MANUF_CODE);
                OFS_W'(1): id_data = DEV_ID;
                OFS_W'(2): id_data = DATA_W'(prot_map[sect_idx]);
                OFS_W'(3): id_data = DATA_W'(CONT_CODE);
                default:   id_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [DATA_W-1:0]       acc_data,
    input  logic                    busy,
    output nor_cmd_pkg::dec_state_t state_o,
    output logic                    start,
    output nor_cmd_pkg::op_code_t   start_op,
    output logic [ADDR_W-1:0]       start_addr,
    output logic [DATA_W-1:0]       start_data
);
    import nor_cmd_pkg::*;

    dec_state_t state_q;
    dec_state_t state_nxt;
    op_code_t   op_nxt;
    logic       take;
    logic       at_a;
    logic       at_b;
    logic [7:0] cmd;

    assign take = wr_stb & ~busy;
    assign at_a = (acc_addr[10:0] == UNLOCK_ADDR_A);
    assign at_b = (acc_addr[10:0] == UNLOCK_ADDR_B);
    assign cmd  = acc_data[7:0];

    // Next state and requested operation.
    always_comb begin
        state_nxt = state_q;
        op_nxt    = OP_NONE;
        if (take) begin
            unique case (state_q)
                ST_READ: begin
                    if (at_a && cmd == CMD_UNLOCK_A) state_nxt = ST_UL1;
                end
                ST_UL1: begin
                    if (at_b && cmd == CMD_UNLOCK_B) state_nxt = ST_UL2;
                    else                             state_nxt = ST_READ;
                end
                ST_UL2: begin
                    if (at_a && cmd == CMD_PROGRAM)      state_nxt = ST_PGM;
                    else if (at_a && cmd == CMD_ERASE)   state_nxt = ST_ERS;
                    else if (at_a && cmd == CMD_AUTOSEL) state_nxt = ST_AUTO;
                    else if (at_a && cmd == CMD_BYPASS)  state_nxt = ST_BYP;
                    else                                 state_nxt = ST_READ;
                end
                ST_PGM: begin
                    op_nxt    = OP_PGM;
                    state_nxt = ST_READ;
                end
                ST_ERS: begin
                    if (at_a && cmd == CMD_UNLOCK_A) state_nxt = ST_EUL1;
                    else                             state_nxt = ST_READ;
                end
                ST_EUL1: begin
                    if (at_b && cmd == CMD_UNLOCK_B) state_nxt = ST_EUL2;
                    else                             state_nxt = ST_READ;
                end
                ST_EUL2: begin
                    if (at_a && cmd == CMD_CHIP)  op_nxt = OP_CHIP;
                    else if (cmd == CMD_SECTOR)   op_nxt = OP_SECT;
                    state_nxt = ST_READ;
                end
                ST_AUTO: begin
                    if (cmd == CMD_RESET) state_nxt = ST_READ;
                end
                ST_BYP: begin
                    if (cmd == CMD_PROGRAM)      state_nxt = ST_BPGM;
                    else if (cmd == CMD_AUTOSEL) state_nxt = ST_BRST;
                end
                ST_BPGM: begin
                    op_nxt    = OP_PGM;
                    state_nxt = ST_BYP;
                end
                ST_BRST: begin
                    if (cmd == CMD_BYP_EXIT) state_nxt = ST_READ;
                    else                     state_nxt = ST_BYP;
                end
                default: state_nxt = ST_READ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_nxt;
    end

    // Output register: start request and its fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start      <= 1'b0;
            start_op   <= OP_NONE;
            start_addr <= '0;
            start_data <= '0;
        end else begin
            start <= (op_nxt != OP_NONE);
            if (op_nxt != OP_NONE) begin
                start_op   <= op_nxt;
                start_addr <= acc_addr;
                start_data <= acc_data;
            end
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int SECT_W = 4,
    parameter logic [7:0] DEV_ID = 8'h1A,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic [NSECT-1:0]  prot_map,
    output logic              start,
    output logic [1:0]        start_op,
    output logic [ADDR_W-1:0] start_addr,
    output logic [DATA_W-1:0] start_data,
    output logic              id_valid,
    output logic [DATA_W-1:0] id_data
);
    import nor_cmd_pkg::*;

    logic              wr_stb;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_data;
    dec_state_t        state;
    op_code_t          op_q;

    nor_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_stb   (wr_stb),
        .acc_addr (acc_addr),
        .acc_data (acc_data)
    );

    nor_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .acc_addr   (acc_addr),
        .acc_data   (acc_data),
        .busy       (busy),
        .state_o    (state),
        .start      (start),
        .start_op   (op_q),
        .start_addr (start_addr),
        .start_data (start_data)
    );

    assign start_op = op_q;

    nor_id_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SECT_W (SECT_W),
        .OFS_W  (8),
        .DEV_ID (DATA_W'(DEV_ID))
    ) u_id (
        .in_auto  (state == ST_AUTO),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .prot_map (prot_map),
        .id_valid (id_valid),
        .id_data  (id_data)
    );

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
    parameter int DATA_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    wr_stb,
    input logic [DATA_W-1:0]       acc_data,
    input nor_cmd_pkg::dec_state_t state,
    input logic                    start,
    input logic [1:0]              start_op
);
    import nor_cmd_pkg::*;

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R2
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ($past(wr_stb) && !$past(busy)));

    // R3
    start_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (start_op != OP_NONE));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && busy) |=> (!start && state == $past(state)));

    // R9
    auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AUTO && !(wr_stb && !busy && acc_data[7:0] == CMD_RESET))
        |=> state == ST_AUTO);

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .wr_stb   (wr_stb),
    .acc_data (acc_data),
    .state    (state),
    .start    (start),
    .start_op (start_op)
);

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          busy = 1'b0;
    logic [15:0]   prot_map = 16'h0004;
    logic          start;
    logic [1:0]    start_op;
    logic [AW-1:0] start_addr;
    logic [7:0]    start_data;
    logic          id_valid;
    logic [7:0]    id_data;

    int checks = 0;
    int errors = 0;
    logic          got_start;
    logic [1:0]    got_op;
    logic [AW-1:0] got_addr;
    logic [7:0]    got_data;

    nor_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .busy(busy), .prot_map(prot_map),
        .start(start), .start_op(start_op), .start_addr(start_addr),
        .start_data(start_data), .id_valid(id_valid), .id_data(id_data)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus write: CE falls first, WE later; the address is valid only in
    // the first open clock and the data only in the last one.
    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = 20'hFFFFF; wdata = 8'hC3;
        @(negedge clk); we_n = 1'b0; addr = a; wdata = 8'h3C;
        @(negedge clk); addr = 20'h0ABCD; wdata = d;
        @(negedge clk); we_n = 1'b1; wdata = 8'h5A;
        @(negedge clk);
        got_start = start; got_op = start_op; got_addr = start_addr; got_data = start_data;
        ce_n = 1'b1;
    endtask

    task automatic wr_none(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        bus_wr(a, d);
        chk(got_start == 1'b0, tag, got_start, 0);
    endtask

    task automatic wr_start(input logic [AW-1:0] a, input logic [7:0] d, input logic [1:0] op,
                            input logic [AW-1:0] ea, input logic [7:0] ed, input string tag);
        bus_wr(a, d);
        chk(got_start == 1'b1, tag, got_start, 1);
        chk(got_op == op, tag, got_op, op);
        chk(got_addr == ea, tag, got_addr, ea);
        chk(got_data == ed, tag, got_data, ed);
    endtask

    task automatic unlock2(input string tag);
        wr_none(20'h00555, 8'hAA, tag);
        wr_none(20'h002AA, 8'h55, tag);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic ev, input logic [7:0] ed,
                          input string tag);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1;
        chk(id_valid == ev, tag, id_valid, ev);
        if (ev) chk(id_data == ed, tag, id_data, ed);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_reset;
        chk(start == 1'b0, "R1 start after reset", start, 0);
        bus_rd(20'h00000, 1'b0, 8'h00, "R1 no id in read mode");
    endtask

    task automatic t_program;
        unlock2("R2 unlock");
        wr_none(20'h00555, 8'hA0, "R2 setup");
        wr_start(20'h12345, 8'h34, 2'b01, 20'h12345, 8'h34, "R2 R11 program start");
        @(negedge clk);
        chk(start == 1'b0, "R2 single pulse", start, 0);
    endtask

    task automatic t_erase;
        unlock2("R3 unlock");
        wr_none(20'h00555, 8'h80, "R3 setup");
        unlock2("R3 unlock2");
        wr_start(20'h00555, 8'h10, 2'b10, 20'h00555, 8'h10, "R3 chip erase");
        unlock2("R3 unlock");
        wr_none(20'h00555, 8'h80, "R3 setup");
        unlock2("R3 unlock2");
        wr_start(20'h70000, 8'h30, 2'b11, 20'h70000, 8'h30, "R3 sector erase");
    endtask

    task automatic t_bypass;
        unlock2("R4 unlock");
        wr_none(20'h00555, 8'h20, "R4 enter bypass");
        wr_none(20'h00000, 8'hA0, "R4 bypass setup");
        wr_start(20'h00100, 8'h11, 2'b01, 20'h00100, 8'h11, "R4 bypass program 1");
        wr_none(20'h00555, 8'h77, "R5 stray write in bypass");
        wr_none(20'h00123, 8'hA0, "R4 bypass setup 2");
        wr_start(20'h00200, 8'h22, 2'b01, 20'h00200, 8'h22, "R4 R5 bypass program 2");
        wr_none(20'h00000, 8'h90, "R5 exit 1");
        wr_none(20'h00000, 8'h00, "R5 exit 2");
        wr_none(20'h00000, 8'hA0, "R5 A0 in read mode");
        wr_none(20'h00300, 8'h33, "R5 no program after exit");
    endtask

    task automatic t_bad;
        wr_none(20'h00555, 8'hAA, "R6 unlock");
        wr_none(20'h00123, 8'h55, "R6 wrong address");
        wr_none(20'h00555, 8'hA0, "R6 after abort");
        wr_none(20'h00400, 8'h44, "R6 no start wrong addr");
        unlock2("R6 unlock");
        wr_none(20'h00555, 8'h77, "R6 wrong value");
        wr_none(20'h00400, 8'h44, "R6 no start wrong value");
        wr_none(20'h002AA, 8'h55, "R6 out of order");
        wr_none(20'h00555, 8'hA0, "R6 out of order setup");
        wr_none(20'h00400, 8'h44, "R6 no start out of order");
    endtask

    task automatic t_rst_cmd;
        unlock2("R7 unlock");
        wr_none(20'h00555, 8'h80, "R7 setup");
        wr_none(20'h0F0F0, 8'hF0, "R7 reset cmd");
        unlock2("R7 unlock");
        wr_none(20'h00555, 8'h10, "R7 no chip erase");
        unlock2("R7 unlock");
        wr_none(20'h00555, 8'hA0, "R7 setup");
        wr_start(20'h00500, 8'h55, 2'b01, 20'h00500, 8'h55, "R7 recovered");
    endtask

    task automatic t_autosel;
        unlock2("R8 unlock");
        wr_none(20'h00555, 8'h90, "R8 enter");
        bus_rd(20'h00000, 1'b1, 8'h37, "R8 manufacturer");
        bus_rd(20'h00001, 1'b1, 8'h1A, "R8 device");
        bus_rd(20'h00003, 1'b1, 8'h7F, "R8 continuation");
        bus_rd(20'h20002, 1'b1, 8'h01, "R8 protected sector");
        bus_rd(20'h30002, 1'b1, 8'h00, "R8 unprotected sector");
        bus_rd(20'h55500, 1'b1, 8'h37, "R8 repeat read");
        wr_none(20'h00555, 8'hA0, "R9 non-reset write");
        bus_rd(20'h00001, 1'b1, 8'h1A, "R9 still autoselect");
        wr_none(20'h00000, 8'hF0, "R9 reset");
        bus_rd(20'h00001, 1'b0, 8'h00, "R9 left autoselect");
    endtask

    task automatic t_busy;
        unlock2("R10 unlock");
        wr_none(20'h00555, 8'hA0, "R10 setup");
        busy = 1'b1;
        wr_none(20'h00000, 8'hF0, "R10 reset ignored");
        wr_none(20'h00600, 8'h66, "R10 data ignored");
        busy = 1'b0;
        wr_start(20'h00700, 8'h77, 2'b01, 20'h00700, 8'h77, "R10 resumed");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_bypass();
        t_bad();
        t_rst_cmd();
        t_autosel();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule